// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block manages a bank of general-purpose pins. Each pin has an 8-bit configuration register, which software writes and reads by pin index. Per pin, the controller works out the value and the enable that go to the pad driver. That resolution takes in the pin's bit of the port data register, the push-pull or open-drain mode, the crystal oscillator enable and a select that gives the pin to a dedicated SPI peripheral. The pull-up, threshold and sink-strength bits pass straight out to the analog pad.

Incoming pin levels pass through a multi-stage synchronizer. The synchronized level is the pin's data-in value. It also feeds an edge detector, which raises a one-cycle interrupt pulse on the configured edge when that pin's interrupt is enabled. The reset input is asserted asynchronously and released in step with the clock.

Configuration bit layout: bit 0 drive enable, bit 1 open-drain, bit 2 pull-up enable, bit 3 TTL threshold select, bit 4 strong sink, bit 5 interrupt enable, bit 6 interrupt polarity (0 rising, 1 falling), bit 7 peripheral select. With default parameters, pins 0 and 1 are the oscillator clock pins. Pins 3, 4, 5 and 6 are the SPI slave-select, clock, MOSI and MISO pins, which use `spi_out`/`spi_oe` bits 0, 1, 2 and 3 respectively.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every configuration register reads 8'h04 (pull-up on, everything else off). Every pin_oe is then 0, every pin_pu is 1, and every pin_ttl and pin_hisink is 0.
- R2: A write with cfg_we high is stored at the next rising clock edge in the register selected by cfg_addr. cfg_rdata combinationally shows the register selected by cfg_addr, and registers that are not addressed keep their values.
- R3: With drive enable (bit 0) set and open-drain (bit 1) clear, pin_oe is 1 and pin_out equals the pin's port_data bit.
- R4: With drive enable and open-drain both set, a port_data bit of 1 gives pin_oe 0 (high impedance). A port_data bit of 0 gives pin_oe 1 with pin_out 0.
- R5: With drive enable (bit 0) clear and no peripheral select in effect, pin_oe is 0 for any port_data value and any open-drain setting.
- R6: While xosc_en is 1, pin_oe of the two clock pins is 0 whatever their configuration. Other pins are unaffected, and the clock pins return to normal when xosc_en falls.
- R7: On the four SPI pins, setting bit 7 makes pin_out and pin_oe follow spi_out and spi_oe bit k. Here k is 0 for slave select, 1 for clock, 2 for MOSI and 3 for MISO. With bit 7 clear, the pin follows the GPIO rules of R3 to R5.
- R8: Bit 7 has no effect on pins that are not SPI pins.
- R9: pin_pu, pin_ttl and pin_hisink equal configuration bits 2, 3 and 4 of the same pin, with no added latency.
- R10: data_in shows a pin_in change after two rising clock edges, not after one.
- R11: With bit 5 set, irq pulses high for one cycle in the same cycle that data_in shows the selected edge: rising when bit 6 is 0, falling when bit 6 is 1. With bit 5 clear, or on the other edge, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W (3) | Pin index for read and write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration of the addressed pin |
| port_data | input | N_PINS (8) | Port data register value |
| xosc_en | input | 1 | Crystal oscillator enable |
| spi_out | input | 4 | SPI peripheral output values |
| spi_oe | input | 4 | SPI peripheral output enables |
| pin_in | input | N_PINS | Raw pad input levels |
| pin_out | output | N_PINS | Value to the pad driver |
| pin_oe | output | N_PINS | Pad driver enable |
| pin_pu | output | N_PINS | Pull-up enable to the pad |
| pin_ttl | output | N_PINS | TTL threshold select to the pad |
| pin_hisink | output | N_PINS | Strong-sink select to the pad |
| data_in | output | N_PINS | Synchronized input levels |
| irq | output | N_PINS | Per-pin edge interrupt pulses |

## Verification
The pad outputs are combinational from the stored configuration and the live inputs. The bench therefore samples them at the falling edge after the write edge, or shortly after it changes port_data, xosc_en or the SPI inputs. Input changes are applied at a falling edge. data_in is checked after one rising edge, where the old value is still expected, and again after the second. The interrupt pulse is checked in that same second-edge cycle and once more a cycle later, when it must be gone. The bench waits for the internal reset release, which lags rst_n by two edges, before it takes its first sample.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int CFG_W = 8;

  // Per-pin configuration word; first field is the MSB.
  typedef struct packed {
    logic periph_sel;  // bit 7: hand pin to dedicated peripheral
    logic irq_low;     // bit 6: 1 = falling edge, 0 = rising edge
    logic irq_en;      // bit 5: interrupt enable
    logic hisink;      // bit 4: strong sink select
    logic ttl;         // bit 3: TTL threshold select
    logic pull_en;     // bit 2: pull-up enable
    logic od;          // bit 1: open-drain mode
    logic drv_en;      // bit 0: output driver enable
  } pin_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RESET_VAL = 8'h04;

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        addr,
  input  logic [CFG_W-1:0]        wdata,
  output pin_cfg_t [N_PINS-1:0]   cfg_o,
  output logic [CFG_W-1:0]        rdata
);

  pin_cfg_t [N_PINS-1:0] cfg_q;
  pin_cfg_t [N_PINS-1:0] cfg_d;
  logic     [N_PINS-1:0] hit;

  for (genvar i = 0; i < N_PINS; i++) begin : g_reg
    assign hit[i] = we && (addr == IDX_W'(i));

    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (hit[i]) cfg_d[i] = pin_cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= pin_cfg_t'(CFG_RESET_VAL);
      else        cfg_q[i] <= cfg_d[i];
    end

    // R2: a write lands at the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (cfg_q[i] == pin_cfg_t'($past(wdata))));
    // R2: unaddressed registers hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(cfg_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_PINS; k++) begin
      if (addr == IDX_W'(k)) rdata = cfg_q[k];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] irq_en,
  input  logic [N_PINS-1:0] irq_low,
  output logic [N_PINS-1:0] data_in,
  output logic [N_PINS-1:0] irq
);

  logic [N_PINS-1:0] stg_q [STAGES];
  logic [N_PINS-1:0] stg_d [STAGES];
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] prev_d;
  logic [N_PINS-1:0] rise;
  logic [N_PINS-1:0] fall;

  always_comb begin
    stg_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
      prev_q <= prev_d;
    end
  end

  assign data_in = stg_q[STAGES-1];
  assign rise    = data_in & ~prev_q;
  assign fall    = ~data_in & prev_q;
  assign irq     = irq_en & ((~irq_low & rise) | (irq_low & fall));

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    // R11: pulse only when enabled
    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> irq_en[i]);
    // R11: pulse matches the configured edge
    p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (data_in[i] == !irq_low[i]));
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter bit IS_CLK  = 1'b0,
  parameter bit HAS_SPI = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_en,
  input  logic od,
  input  logic pull_en,
  input  logic ttl,
  input  logic hisink,
  input  logic periph_sel,
  input  logic data_bit,
  input  logic xosc_en,
  input  logic per_out,
  input  logic per_oe,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pu,
  output logic pad_ttl,
  output logic pad_sink
);

  logic gpio_oe;
  logic gpio_out;
  logic take;
  logic oe_pre;
  logic out_pre;
  logic osc_block;

  always_comb begin
    gpio_oe   = drv_en & ~(od & data_bit);
    gpio_out  = data_bit & ~od;
    take      = HAS_SPI && periph_sel;
    oe_pre    = take ? per_oe  : gpio_oe;
    out_pre   = take ? per_out : gpio_out;
    osc_block = IS_CLK && xosc_en;
  end

  assign pad_oe   = oe_pre & ~osc_block;
  assign pad_out  = out_pre;
  assign pad_pu   = pull_en;
  assign pad_ttl  = ttl;
  assign pad_sink = hisink;

  // R4: open-drain with data 1 floats
  p_od_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && od && data_bit) |-> !pad_oe);
  // R4: open-drain only ever drives low
  p_od_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && od && pad_oe) |-> !pad_out);
  // R5: driver off when enable bit clear
  p_drv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !drv_en) |-> !pad_oe);

  if (IS_CLK) begin : g_osc_chk
    // R6: oscillator owns the clock pins
    p_xosc_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xosc_en |-> !pad_oe);
  end

  if (HAS_SPI) begin : g_spi_chk
    // R7: selected pin follows the peripheral
    p_spi_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      periph_sel |-> (pad_oe == per_oe && pad_out == per_out));
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int N_PINS       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int CLKIN_IDX    = 0,
  parameter int CLKOUT_IDX   = 1,
  parameter int SPI_SS_IDX   = 3,
  parameter int SPI_SCK_IDX  = 4,
  parameter int SPI_MOSI_IDX = 5,
  parameter int SPI_MISO_IDX = 6,
  localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [N_PINS-1:0] port_data,
  input  logic              xosc_en,
  input  logic [3:0]        spi_out,
  input  logic [3:0]        spi_oe,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_pu,
  output logic [N_PINS-1:0] pin_ttl,
  output logic [N_PINS-1:0] pin_hisink,
  output logic [N_PINS-1:0] data_in,
  output logic [N_PINS-1:0] irq
);

  // Reset: asynchronous assert, release aligned to clk
  logic rst_meta_q;
  logic rst_sync_q;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_i = rst_sync_q;

  pin_cfg_t [N_PINS-1:0] cfg;
  logic     [N_PINS-1:0] irq_en_v;
  logic     [N_PINS-1:0] irq_low_v;

  gpio_cfg_bank #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg_o (cfg),
    .rdata (cfg_rdata)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    localparam bit IS_CLK = (i == CLKIN_IDX) || (i == CLKOUT_IDX);
    localparam int SLOT   = (i == SPI_SS_IDX)   ? 0 :
                            (i == SPI_SCK_IDX)  ? 1 :
                            (i == SPI_MOSI_IDX) ? 2 :
                            (i == SPI_MISO_IDX) ? 3 : -1;
    localparam bit HAS_SPI = (SLOT >= 0);
    localparam int SLOT_SAFE = HAS_SPI ? SLOT : 0;

    assign irq_en_v[i]  = cfg[i].irq_en;
    assign irq_low_v[i] = cfg[i].irq_low;

    gpio_pad_mux #(.IS_CLK(IS_CLK), .HAS_SPI(HAS_SPI)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n_i),
      .drv_en     (cfg[i].drv_en),
      .od         (cfg[i].od),
      .pull_en    (cfg[i].pull_en),
      .ttl        (cfg[i].ttl),
      .hisink     (cfg[i].hisink),
      .periph_sel (cfg[i].periph_sel),
      .data_bit   (port_data[i]),
      .xosc_en    (xosc_en),
      .per_out    (spi_out[SLOT_SAFE]),
      .per_oe     (spi_oe[SLOT_SAFE]),
      .pad_out    (pin_out[i]),
      .pad_oe     (pin_oe[i]),
      .pad_pu     (pin_pu[i]),
      .pad_ttl    (pin_ttl[i]),
      .pad_sink   (pin_hisink[i])
    );
  end

  gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .pin_in  (pin_in),
    .irq_en  (irq_en_v),
    .irq_low (irq_low_v),
    .data_in (data_in),
    .irq     (irq)
  );

  // R1: pads stay undriven while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_i |-> (pin_oe == '0));

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [2:0]   cfg_addr;
  logic [7:0]   cfg_wdata;
  logic [7:0]   cfg_rdata;
  logic [N-1:0] port_data;
  logic         xosc_en;
  logic [3:0]   spi_out;
  logic [3:0]   spi_oe;
  logic [N-1:0] pin_in;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;
  logic [N-1:0] pin_pu;
  logic [N-1:0] pin_ttl;
  logic [N-1:0] pin_hisink;
  logic [N-1:0] data_in;
  logic [N-1:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .port_data(port_data),
    .xosc_en(xosc_en), .spi_out(spi_out), .spi_oe(spi_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_ttl(pin_ttl),
    .pin_hisink(pin_hisink), .data_in(data_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ends at a falling edge with the new value in place
  task automatic write_cfg(input int idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_cfg(input int idx, output logic [7:0] val);
    cfg_addr = 3'(idx);
    #1 val = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < N; i++) begin
      read_cfg(i, v);
      check("R1 cfg reset", v, 8'h04);
    end
    check("R1 oe reset", pin_oe, 8'h00);
    check("R1 pu reset", pin_pu, 8'hFF);
    check("R1 ttl reset", pin_ttl, 8'h00);
    check("R1 sink reset", pin_hisink, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    write_cfg(2, 8'h5A);
    read_cfg(2, v);  check("R2 readback", v, 8'h5A);
    read_cfg(3, v);  check("R2 neighbour held", v, 8'h04);
    write_cfg(7, 8'hC3);
    read_cfg(7, v);  check("R2 readback pin7", v, 8'hC3);
    read_cfg(2, v);  check("R2 earlier write kept", v, 8'h5A);
  endtask

  task automatic t_pushpull();
    write_cfg(2, 8'h01);
    port_data = 8'h04; #1;
    check("R3 oe", pin_oe[2], 1'b1);
    check("R3 out high", pin_out[2], 1'b1);
    port_data = 8'h00; #1;
    check("R3 out low", pin_out[2], 1'b0);
    check("R3 oe low data", pin_oe[2], 1'b1);
  endtask

  task automatic t_opendrain();
    write_cfg(2, 8'h03);
    port_data = 8'h04; #1;
    check("R4 hiz on 1", pin_oe[2], 1'b0);
    port_data = 8'h00; #1;
    check("R4 drive on 0", pin_oe[2], 1'b1);
    check("R4 drive low", pin_out[2], 1'b0);
  endtask

  task automatic t_off();
    write_cfg(2, 8'h02);
    port_data = 8'h00; #1;
    check("R5 off od data0", pin_oe[2], 1'b0);
    write_cfg(2, 8'h00);
    port_data = 8'hFF; #1;
    check("R5 off pp data1", pin_oe[2], 1'b0);
  endtask

  task automatic t_xosc();
    write_cfg(0, 8'h01);
    write_cfg(1, 8'h01);
    write_cfg(7, 8'h01);
    port_data = 8'hFF; xosc_en = 1'b1; #1;
    check("R6 clock pins blocked", pin_oe[1:0], 2'b00);
    check("R6 other pin free", pin_oe[7], 1'b1);
    xosc_en = 1'b0; #1;
    check("R6 released", pin_oe[1:0], 2'b11);
  endtask

  task automatic t_spi();
    for (int p = 3; p <= 6; p++) write_cfg(p, 8'h81);
    port_data = 8'h00; spi_out = 4'b1010; spi_oe = 4'b0110; #1;
    check("R7 spi out", pin_out[6:3], 4'b1010);
    check("R7 spi oe", pin_oe[6:3], 4'b0110);
    spi_out = 4'b0101; spi_oe = 4'b1001; #1;
    check("R7 spi out swap", pin_out[6:3], 4'b0101);
    check("R7 spi oe swap", pin_oe[6:3], 4'b1001);
    for (int p = 3; p <= 6; p++) write_cfg(p, 8'h01);
    port_data = 8'hFF; #1;
    check("R7 gpio back out", pin_out[6:3], 4'b1111);
    check("R7 gpio back oe", pin_oe[6:3], 4'b1111);
  endtask

  task automatic t_nonspi();
    write_cfg(7, 8'h81);
    spi_out = 4'b0000; spi_oe = 4'b0000; port_data = 8'h80; #1;
    check("R8 sel ignored oe", pin_oe[7], 1'b1);
    check("R8 sel ignored out", pin_out[7], 1'b1);
    write_cfg(7, 8'h83);
    #1 check("R8 sel ignored od", pin_oe[7], 1'b0);
  endtask

  task automatic t_pad();
    write_cfg(5, 8'h18);
    check("R9 pu", pin_pu[5], 1'b0);
    check("R9 ttl", pin_ttl[5], 1'b1);
    check("R9 sink", pin_hisink[5], 1'b1);
    write_cfg(5, 8'h04);
    check("R9 restore", {pin_pu[5], pin_ttl[5], pin_hisink[5]}, 3'b100);
  endtask

  task automatic t_sync();
    @(negedge clk); pin_in[2] = 1'b1;
    @(negedge clk); check("R10 not after one edge", data_in[2], 1'b0);
    @(negedge clk); check("R10 after two edges", data_in[2], 1'b1);
    pin_in[2] = 1'b0;
    @(negedge clk); check("R10 fall one edge", data_in[2], 1'b1);
    @(negedge clk); check("R10 fall two edges", data_in[2], 1'b0);
  endtask

  task automatic t_irq();
    write_cfg(4, 8'h20);
    pin_in[4] = 1'b1;
    @(negedge clk); check("R11 rise early", irq[4], 1'b0);
    @(negedge clk); check("R11 rise pulse", irq[4], 1'b1);
    @(negedge clk); check("R11 rise one cycle", irq[4], 1'b0);
    pin_in[4] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); check("R11 wrong edge", irq[4], 1'b0);
    end
    write_cfg(4, 8'h60);
    pin_in[4] = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); check("R11 rise ignored falling mode", irq[4], 1'b0);
    end
    pin_in[4] = 1'b0;
    @(negedge clk); check("R11 fall early", irq[4], 1'b0);
    @(negedge clk); check("R11 fall pulse", irq[4], 1'b1);
    @(negedge clk); check("R11 fall one cycle", irq[4], 1'b0);
    write_cfg(4, 8'h00);
    pin_in[4] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); check("R11 disabled", irq[4], 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    port_data = '0; xosc_en = 1'b0; spi_out = '0; spi_oe = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_pushpull();
    t_opendrain();
    t_off();
    t_xosc();
    t_spi();
    t_nonspi();
    t_pad();
    t_sync();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule